// File: doc/BRIEF.md
# Serial PCM Voice Sample Port

This block moves 13-bit two's complement voice samples between a converter core and a full-duplex serial link. The transmit side takes a parallel sample, latches it when a frame opens and shifts it out sign bit first on a data line that has its own enable, so the line is undriven between words. The receive side samples a serial data line on bit clock falling edges, rebuilds the word and hands it to the converter core with a one-cycle strobe. The serial pins are treated as slow levels and are examined on every edge of a faster system clock.

A format input selects one of three framings. In the asynchronous framing each direction moves 13 bits on its own bit clock. In the sign-extended framing both directions move 16 bits on the transmit bit clock, and the first four bits are copies of the sign. In the gain framing both directions use the transmit bit clock: transmit moves 13 bits, and receive moves 16 bits, which are the 13 voice bits followed by a 3-bit attenuation code. A separate input chooses between a frame sync that is one bit clock wide and a frame sync that spans the word. When the receive side stops framing while transmit keeps going, the sample offered to the decoder is forced to zero. A power-down input from the supervisor silences the port.

Top module: `pcm_voice_port`

## Requirements
- R1: After reset, tx_dout_en, tx_dout, rx_valid, rx_sample and rx_atten are all 0.
- R2: With fs_long=0, a frame opens on a bit clock falling edge that sees the frame sync high; the sign bit is driven from the next bit clock rising edge, each later rising edge moves to the next bit, and the enable drops after the 13th falling edge (16th in the sign-extended framing).
- R3: With fs_long=1, a frame opens on the frame sync rising edge; the sign bit is driven at the later of that edge and a bit clock rising edge, and the enable drops at the later of the 13th (or 16th) bit clock falling edge and the frame sync falling edge.
- R4: Receive bits are sampled on the falling edges that follow the frame start, MSB first; on the last bit rx_valid pulses high for exactly one system clock and rx_sample carries the new word.
- R5: fmt=01 (sign-extended): transmit sends 16 bits, the first four being the sign; receive takes 16 bits on tx_bclk and rx_sample is the last 13 of them.
- R6: fmt=10 (gain): transmit sends 13 bits; receive takes 16 bits on tx_bclk, the first 13 form rx_sample and the last 3 form rx_atten, where code 000 means 0 dB and each step adds 3 dB of attenuation up to 21 dB at 111; rx_atten changes only on a strobe of this framing.
- R7: The transmit word is captured when the frame opens; a change of tx_sample during the frame does not alter the bits sent.
- R8: Once HALF_FRAMES transmit frames have opened with no receive frame opening, rx_sample reads zero until the next receive frame opens.
- R9: While pwr_dn is high, tx_dout_en stays low, rx_valid never pulses and frame syncs are ignored.
- R10: fmt=00 (and the unused code 11): the receive side runs on rx_bclk alone, independent of tx_bclk.
- R11: tx_dout is 0 whenever tx_dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_dn | input | 1 | Power-down request from the supervisor |
| fmt | input | 2 | Framing: 00 async 13-bit, 01 sign-extended, 10 gain, 11 as 00 |
| fs_long | input | 1 | 1 = frame sync spans the word, 0 = one bit clock wide |
| tx_fs | input | 1 | Transmit frame sync |
| tx_bclk | input | 1 | Transmit bit clock (also receive clock in sync framings) |
| tx_dout | output | 1 | Serial transmit data |
| tx_dout_en | output | 1 | Drive enable for tx_dout (0 = high impedance) |
| rx_fs | input | 1 | Receive frame sync |
| rx_bclk | input | 1 | Receive bit clock in the asynchronous framing |
| rx_din | input | 1 | Serial receive data |
| tx_sample | input | 13 | Parallel sample from the encoder |
| rx_sample | output | 13 | Parallel sample to the decoder |
| rx_valid | output | 1 | One-cycle strobe for a completed receive word |
| rx_atten | output | 3 | Last received attenuation code |

## Verification
The assertions assume the serial pins are already synchronous to clk and that each bit clock half period spans at least two system clocks, so that a rising edge is seen as a clean 0-then-1 pair of samples and no two bit clock edges fall in adjacent cycles. They also assume the format and frame sync style are held steady across a frame. The stimulus keeps every bit clock half period at four system clocks, changes pins only on the falling edge of clk, and sets fmt and fs_long before a frame opens.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        FMT_ASYNC = 2'd0,
        FMT_SEXT  = 2'd1,
        FMT_GAIN  = 2'd2,
        FMT_RSVD  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_ARMED  = 2'd1,
        TX_ACTIVE = 2'd2
    } tx_st_e;

    function automatic logic fmt_is_sync(fmt_e f);
        return (f == FMT_SEXT) || (f == FMT_GAIN);
    endfunction

endpackage

// File: rtl/pcm_edge_reg.sv
module pcm_edge_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] prev_o
);
    logic [N-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign prev_o = lvl_q;
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 13,
    parameter int ATT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_dn_i,
    input  fmt_e                fmt_i,
    input  logic                fs_long_i,
    input  logic                fs_i,
    input  logic                fs_rise_i,
    input  logic                bclk_i,
    input  logic                bclk_rise_i,
    input  logic                bclk_fall_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                frame_start_o,
    output logic                dout_o,
    output logic                dout_en_o
);
    localparam int WORD_W = SAMPLE_W + ATT_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(SAMPLE_W);

    typedef struct packed {
        tx_st_e            st;
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              done;
    } tx_reg_t;

    tx_reg_t          r_d, r_q;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] cnt_inc;
    logic             start_ev;

    always_comb begin
        r_d           = r_q;
        frame_start_o = 1'b0;
        len           = (fmt_i == FMT_SEXT) ? LEN_WIDE : LEN_NARROW;
        cnt_inc       = r_q.cnt + 1'b1;
        // long sync opens on its own edge; short sync is caught by a falling bit clock
        start_ev      = fs_long_i ? fs_rise_i : (bclk_fall_i && fs_i);

        if (pwr_dn_i) begin
            r_d.st   = TX_IDLE;
            r_d.cnt  = '0;
            r_d.done = 1'b0;
        end else begin
            case (r_q.st)
                TX_IDLE: begin
                    if (start_ev) begin
                        frame_start_o = 1'b1;
                        r_d.cnt  = '0;
                        r_d.done = 1'b0;
                        r_d.sh   = (fmt_i == FMT_SEXT)
                                 ? {{ATT_W{sample_i[SAMPLE_W-1]}}, sample_i}
                                 : {sample_i, {ATT_W{1'b0}}};
                        // bit clock already high: the sync edge is the later event
                        r_d.st   = (fs_long_i && bclk_i) ? TX_ACTIVE : TX_ARMED;
                    end
                end
                TX_ARMED: begin
                    if (bclk_rise_i) r_d.st = TX_ACTIVE;
                end
                TX_ACTIVE: begin
                    if (r_q.done) begin
                        if (!fs_i) r_d.st = TX_IDLE;
                    end else begin
                        if (bclk_rise_i) r_d.sh = {r_q.sh[WORD_W-2:0], 1'b0};
                        if (bclk_fall_i) begin
                            r_d.cnt = cnt_inc;
                            if (cnt_inc == len) begin
                                if (!fs_long_i || !fs_i) r_d.st   = TX_IDLE;
                                else                     r_d.done = 1'b1;
                            end
                        end
                    end
                end
                default: r_d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: TX_IDLE, sh: '0, cnt: '0, done: 1'b0};
        else        r_q <= r_d;
    end

    assign dout_en_o = (r_q.st == TX_ACTIVE);
    assign dout_o    = dout_en_o & r_q.sh[WORD_W-1];
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 13,
    parameter int ATT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_dn_i,
    input  fmt_e                fmt_i,
    input  logic                fs_long_i,
    input  logic                fs_i,
    input  logic                fs_rise_i,
    input  logic                bclk_fall_i,
    input  logic                din_i,
    output logic                frame_start_o,
    output logic                valid_o,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic [ATT_W-1:0]    atten_o
);
    localparam int WORD_W = SAMPLE_W + ATT_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(SAMPLE_W);

    typedef struct packed {
        logic                act;
        logic [WORD_W-1:0]   sh;
        logic [CNT_W-1:0]    cnt;
        logic                vld;
        logic [SAMPLE_W-1:0] smp;
        logic [ATT_W-1:0]    att;
    } rx_reg_t;

    rx_reg_t           r_d, r_q;
    logic [WORD_W-1:0] sh_n;
    logic [CNT_W-1:0]  len;
    logic [CNT_W-1:0]  cnt_inc;
    logic              start_ev;

    always_comb begin
        r_d           = r_q;
        r_d.vld       = 1'b0;
        frame_start_o = 1'b0;
        sh_n          = {r_q.sh[WORD_W-2:0], din_i};
        cnt_inc       = r_q.cnt + 1'b1;
        len           = fmt_is_sync(fmt_i) ? LEN_WIDE : LEN_NARROW;
        start_ev      = fs_long_i ? fs_rise_i : (bclk_fall_i && fs_i);

        if (pwr_dn_i) begin
            r_d.act = 1'b0;
            r_d.cnt = '0;
        end else if (!r_q.act) begin
            if (start_ev) begin
                frame_start_o = 1'b1;
                r_d.act = 1'b1;
                r_d.cnt = '0;
            end
        end else if (bclk_fall_i) begin
            r_d.sh  = sh_n;
            r_d.cnt = cnt_inc;
            if (cnt_inc == len) begin
                r_d.act = 1'b0;
                r_d.vld = 1'b1;
                if (fmt_i == FMT_GAIN) begin
                    r_d.smp = sh_n[WORD_W-1:ATT_W];
                    r_d.att = sh_n[ATT_W-1:0];
                end else begin
                    r_d.smp = sh_n[SAMPLE_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign valid_o  = r_q.vld;
    assign sample_o = r_q.smp;
    assign atten_o  = r_q.att;
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W    = 13,
    parameter int ATT_W       = 3,
    parameter int HALF_FRAMES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_dn,
    input  logic [1:0]          fmt,
    input  logic                fs_long,
    input  logic                tx_fs,
    input  logic                tx_bclk,
    output logic                tx_dout,
    output logic                tx_dout_en,
    input  logic                rx_fs,
    input  logic                rx_bclk,
    input  logic                rx_din,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid,
    output logic [ATT_W-1:0]    rx_atten
);
    localparam int HC_W = $clog2(HALF_FRAMES + 1);
    localparam logic [HC_W-1:0] HALF_LIM = HC_W'(HALF_FRAMES);
    localparam int NSIG   = 4;
    localparam int IX_TFS = 0;
    localparam int IX_TBC = 1;
    localparam int IX_RFS = 2;
    localparam int IX_RBC = 3;

    typedef struct packed {
        logic [HC_W-1:0] hcnt;
    } top_reg_t;

    fmt_e                mode;
    logic                rx_bclk_sel;
    logic [NSIG-1:0]     raw, prev;
    logic                tfs_rise, tbc_rise, tbc_fall, rfs_rise, rbc_fall;
    logic                tx_start, rx_start;
    logic [SAMPLE_W-1:0] rx_word;
    top_reg_t            t_d, t_q;

    assign mode        = fmt_e'(fmt);
    assign rx_bclk_sel = fmt_is_sync(mode) ? tx_bclk : rx_bclk;
    assign raw         = {rx_bclk_sel, rx_fs, tx_bclk, tx_fs};

    pcm_edge_reg #(.N(NSIG)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (raw),
        .prev_o (prev)
    );

    assign tfs_rise = raw[IX_TFS] & ~prev[IX_TFS];
    assign tbc_rise = raw[IX_TBC] & ~prev[IX_TBC];
    assign tbc_fall = ~raw[IX_TBC] & prev[IX_TBC];
    assign rfs_rise = raw[IX_RFS] & ~prev[IX_RFS];
    assign rbc_fall = ~raw[IX_RBC] & prev[IX_RBC];

    pcm_tx_ser #(.SAMPLE_W(SAMPLE_W), .ATT_W(ATT_W)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_dn_i      (pwr_dn),
        .fmt_i         (mode),
        .fs_long_i     (fs_long),
        .fs_i          (tx_fs),
        .fs_rise_i     (tfs_rise),
        .bclk_i        (tx_bclk),
        .bclk_rise_i   (tbc_rise),
        .bclk_fall_i   (tbc_fall),
        .sample_i      (tx_sample),
        .frame_start_o (tx_start),
        .dout_o        (tx_dout),
        .dout_en_o     (tx_dout_en)
    );

    pcm_rx_deser #(.SAMPLE_W(SAMPLE_W), .ATT_W(ATT_W)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_dn_i      (pwr_dn),
        .fmt_i         (mode),
        .fs_long_i     (fs_long),
        .fs_i          (rx_fs),
        .fs_rise_i     (rfs_rise),
        .bclk_fall_i   (rbc_fall),
        .din_i         (rx_din),
        .frame_start_o (rx_start),
        .valid_o       (rx_valid),
        .sample_o      (rx_word),
        .atten_o       (rx_atten)
    );

    // transmit frames opened since the receive side last framed
    always_comb begin
        t_d = t_q;
        if (rx_start)
            t_d.hcnt = '0;
        else if (tx_start && (t_q.hcnt != HALF_LIM))
            t_d.hcnt = t_q.hcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rx_sample = (t_q.hcnt == HALF_LIM) ? '0 : rx_word;
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk #(
    parameter int ATT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_dn,
    input logic [1:0]       fmt,
    input logic             tx_bclk,
    input logic             tx_dout,
    input logic             tx_dout_en,
    input logic             rx_valid,
    input logic [ATT_W-1:0] rx_atten
);
    // R9
    pd_quiets_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!tx_dout_en && !rx_valid));

    // R11
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_dout_en |-> !tx_dout);

    // R4
    rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R2, R3
    tx_enable_on_high_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_dout_en) |-> $past(tx_bclk));

    // R2
    tx_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dout_en && $past(tx_dout_en) && !$stable(tx_dout))
            |-> ($past(tx_bclk) && !$past(tx_bclk, 2)));

    // R6
    atten_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_atten) |-> (rx_valid && ($past(fmt) == 2'd2)));
endmodule

bind pcm_voice_port pcm_voice_port_chk #(.ATT_W(ATT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn     (pwr_dn),
    .fmt        (fmt),
    .tx_bclk    (tx_bclk),
    .tx_dout    (tx_dout),
    .tx_dout_en (tx_dout_en),
    .rx_valid   (rx_valid),
    .rx_atten   (rx_atten)
);

// File: tb/sim_pcm_voice_port.sv
module sim_pcm_voice_port;
    localparam int CLK_P = 10;
    localparam int H     = 4;
    localparam int NV    = 12;

    typedef struct packed {
        logic [1:0]  fmt;
        logic        lng;
        logic [12:0] txs;
        logic [15:0] rxw;
        logic        chg;
        logic        tck;
        logic        rck;
        logic        tfs;
        logic        rfs;
        logic        pd;
        logic [4:0]  entx;
        logic [15:0] etx;
        logic [1:0]  env;
        logic [12:0] ers;
        logic [2:0]  eatt;
    } vec_t;

    // fmt lng txs rxw chg tck rck tfs rfs pd | entx etx env ers eatt
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 13'h0FFF, 16'h8000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd13, 16'h0FFF, 2'd1, 13'h1000, 3'd0},
        '{2'd0, 1'b1, 13'h1000, 16'h7FF8, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd13, 16'h1000, 2'd1, 13'h0FFF, 3'd0},
        '{2'd0, 1'b0, 13'h1FFF, 16'hAAA8, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd13, 16'h1FFF, 2'd1, 13'h1555, 3'd0},
        '{2'd1, 1'b0, 13'h1ABC, 16'h0123, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd16, 16'hFABC, 2'd1, 13'h0123, 3'd0},
        '{2'd1, 1'b1, 13'h0456, 16'hFF00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd16, 16'h0456, 2'd1, 13'h1F00, 3'd0},
        '{2'd2, 1'b0, 13'h0ABC, 16'h190D, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd13, 16'h0ABC, 2'd1, 13'h0321, 3'd5},
        '{2'd2, 1'b1, 13'h1001, 16'hFFF7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd13, 16'h1001, 2'd1, 13'h1FFE, 3'd7},
        '{2'd0, 1'b0, 13'h0000, 16'h0210, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  16'h0000, 2'd1, 13'h0042, 3'd7},
        '{2'd0, 1'b0, 13'h0007, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd13, 16'h0007, 2'd0, 13'h0042, 3'd7},
        '{2'd0, 1'b0, 13'h0AAA, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd0,  16'h0000, 2'd0, 13'h0042, 3'd7},
        '{2'd0, 1'b0, 13'h1F00, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd13, 16'h1F00, 2'd0, 13'h0000, 3'd7},
        '{2'd0, 1'b0, 13'h0000, 16'h55E0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd13, 16'h0000, 2'd1, 13'h0ABC, 3'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        fs_long = 1'b0;
    logic        tx_fs = 1'b0;
    logic        tx_bclk = 1'b0;
    logic        rx_fs = 1'b0;
    logic        rx_bclk = 1'b0;
    logic        rx_din = 1'b0;
    logic [12:0] tx_sample = '0;
    logic        tx_dout, tx_dout_en, rx_valid;
    logic [12:0] rx_sample;
    logic [2:0]  rx_atten;

    int n_chk = 0;
    int n_bad = 0;
    int nv    = 0;

    always #(CLK_P/2) clk = ~clk;

    pcm_voice_port u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_dn     (pwr_dn),
        .fmt        (fmt),
        .fs_long    (fs_long),
        .tx_fs      (tx_fs),
        .tx_bclk    (tx_bclk),
        .tx_dout    (tx_dout),
        .tx_dout_en (tx_dout_en),
        .rx_fs      (rx_fs),
        .rx_bclk    (rx_bclk),
        .rx_din     (rx_din),
        .tx_sample  (tx_sample),
        .rx_sample  (rx_sample),
        .rx_valid   (rx_valid),
        .rx_atten   (rx_atten)
    );

    always @(negedge clk) if (rx_valid) nv++;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0: return "R2 R4";
            1: return "R3 R4";
            2: return "R7 R4";
            3: return "R5";
            4: return "R5 R3";
            5: return "R6";
            6: return "R6 R3";
            7: return "R10";
            8: return "R8 R2";
            9: return "R9";
            10: return "R8";
            default: return "R8 R4";
        endcase
    endfunction

    task automatic run_frame(input vec_t v, output int ntx, output logic [15:0] cap);
        fmt = v.fmt; fs_long = v.lng; tx_sample = v.txs; pwr_dn = v.pd;
        ntx = 0; cap = '0;
        wait_clk(H);
        if (!v.lng) begin
            if (v.tfs) tx_fs = 1'b1;
            if (v.rfs) rx_fs = 1'b1;
        end
        if (v.tck) tx_bclk = 1'b1;
        if (v.rck) rx_bclk = 1'b1;
        wait_clk(H);
        tx_bclk = 1'b0; rx_bclk = 1'b0;
        wait_clk(H);
        if (v.lng) begin
            if (v.tfs) tx_fs = 1'b1;
            if (v.rfs) rx_fs = 1'b1;
            wait_clk(H);
        end
        for (int k = 0; k < 19; k++) begin
            if (v.tck) tx_bclk = 1'b1;
            if (v.rck) rx_bclk = 1'b1;
            if ((!v.lng && k == 0) || (v.lng && k == 8)) begin
                tx_fs = 1'b0; rx_fs = 1'b0;
            end
            rx_din = (k < 16) ? v.rxw[15-k] : 1'b0;
            if (v.chg && k == 5) tx_sample = ~tx_sample;
            wait_clk(H);
            if (tx_dout_en) begin
                ntx++;
                cap = {cap[14:0], tx_dout};
            end
            tx_bclk = 1'b0; rx_bclk = 1'b0;
            wait_clk(H);
        end
        wait_clk(4);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state, R11 idle line
        chk("R1 tx_dout_en", 32'(tx_dout_en), 32'd0);
        chk("R1 rx_valid", 32'(rx_valid), 32'd0);
        chk("R1 rx_sample", 32'(rx_sample), 32'd0);
        chk("R1 rx_atten", 32'(rx_atten), 32'd0);
        chk("R11 tx_dout idle", 32'(tx_dout), 32'd0);

        for (int i = 0; i < NV; i++) begin
            int          ntx;
            logic [15:0] cap;
            nv = 0;
            run_frame(VECS[i], ntx, cap);
            chk({row_tag(i), " tx bit count"}, 32'(ntx), 32'(VECS[i].entx));
            chk({row_tag(i), " tx bits"}, 32'(cap), 32'(VECS[i].etx));
            chk({row_tag(i), " rx strobes"}, 32'(nv), 32'(VECS[i].env));
            chk({row_tag(i), " rx_sample"}, 32'(rx_sample), 32'(VECS[i].ers));
            chk({row_tag(i), " rx_atten"}, 32'(rx_atten), 32'(VECS[i].eatt));
        end

        // R3 corner: sync rises while bit clock is high, and stays high past the last bit
        begin
            logic [15:0] cap = '0;
            pwr_dn = 1'b0; fmt = 2'd0; fs_long = 1'b1; tx_sample = 13'h1234;
            wait_clk(H);
            tx_bclk = 1'b1;
            wait_clk(H);
            tx_fs = 1'b1;
            wait_clk(2);
            chk("R3 enable at sync edge", 32'(tx_dout_en), 32'd1);
            chk("R3 sign bit at sync edge", 32'(tx_dout), 32'd1);
            cap = {cap[14:0], tx_dout};
            tx_bclk = 1'b0;
            wait_clk(H);
            for (int j = 1; j < 13; j++) begin
                tx_bclk = 1'b1;
                wait_clk(H);
                cap = {cap[14:0], tx_dout};
                tx_bclk = 1'b0;
                wait_clk(H);
            end
            wait_clk(3);
            chk("R3 bits with early sync", 32'(cap), 32'h1234);
            chk("R3 held while sync high", 32'(tx_dout_en), 32'd1);
            tx_fs = 1'b0;
            wait_clk(3);
            chk("R3 released at sync fall", 32'(tx_dout_en), 32'd0);
            chk("R11 line low after release", 32'(tx_dout), 32'd0);
        end

        finish_run();
    end

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule